// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block watches a bus of one-cycle event strobes from a memory controller and counts them in four counters that software reaches through a small register port. Slot 0 is a free cycle counter. Slots 1 to 3 each count one event line, picked by an 8-bit code written into that slot's control word.

The cycle counter acts as the master timebase. When it wraps, it latches its overflow flag, freezes all four counters at the same clock edge, and raises a level interrupt. Software then reads every slot, clears, and restarts.

A strap input sets what an event counter does when it runs out of range. In one setting it wraps and keeps counting. In the other it holds its top value until software clears it. The clear bit behaves differently on the two kinds of slot. An event slot is cleared by writing 0 to that bit, and the bit then reads back as 1. The cycle slot is cleared only when its stored clear bit goes from 0 to 1.

Top module: `memperf_monitor`

## Requirements
- R1: After reset every count reads 0, control word 0 reads 0x00000000, control words 1 to 3 read 0x00000002, and `irq_o` is low.
- R2: The control word of slot n is at byte address 4n and its count is at 0x20 + 4n. Control fields are: overflow flag in bit 0 (read only), clear in bit 1, enable in bit 2, and the event code in bits 31:24. Any other address, including unaligned ones, reads 0 and ignores writes. Count addresses are read only.
- R3: While its enable bit is 1 and its overflow flag is 0, the cycle counter adds one on every clock. Its event-code field always reads 0.
- R4: An enabled event slot with code k, where 1 <= k < EV_N, adds one on each clock where `events_i[k]` is 1 and the cycle counter is running. Code 0, codes >= EV_N and a disabled slot count nothing.
- R5: When the cycle counter passes its maximum, it wraps to 0 and sets its overflow flag. From that edge on, all four counts are frozen and `irq_o` stays high until the flag is cleared.
- R6: Clearing the cycle counter's enable bit stops all event slots. Setting it again lets them resume.
- R7: With `wrap_mode_i` = 1, an event slot that passes its maximum goes to 0, sets its overflow flag, keeps counting, and leaves `irq_o` unchanged.
- R8: With `wrap_mode_i` = 0, an event slot that reaches its maximum and sees one more event sets its overflow flag and holds the all-ones value until it is cleared. It leaves `irq_o` unchanged.
- R9: A write to an event slot's control word with bit 1 = 0 zeroes that slot's count and overflow flag. Bit 1 then reads 1.
- R10: The cycle counter's count and overflow flag are cleared only by a write that changes its stored bit 1 from 0 to 1. Writing 1 over a stored 1 clears nothing. Clearing the flag drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_mode_i | input | 1 | Strap: 1 = event slots wrap, 0 = event slots hold on overflow |
| events_i | input | EV_N | One-cycle event strobes, indexed by event code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, high while the cycle counter's overflow flag is set |

## Verification
The assertions assume three things about the inputs: `wrap_mode_i` changes only while no event slot is counting, and the register port presents at most one write per clock, held for exactly one cycle. The stimulus meets these conditions. Writes are driven on the falling edge and released one cycle later. The strap is changed only while the cycle counter is disabled. Event strobes are raised only between the write that enables the cycle counter and the write that disables it, so the expected counts follow directly from the number of strobe cycles.

// File: rtl/memperf_pkg.sv
package memperf_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_CNT  = 4;
    localparam int SEL_W    = 8;
    localparam int OVF_BIT  = 0;
    localparam int CLR_BIT  = 1;
    localparam int EN_BIT   = 2;
    localparam int SEL_LSB  = 24;
    localparam int CTRL_OFS = 'h00;
    localparam int CNT_OFS  = 'h20;
    typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/memperf_cyc_cnt.sv
module memperf_cyc_cnt #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             wr_en_i,
    input  logic             wr_clr_i,
    output logic [CYC_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             clr_o,
    output logic             en_o,
    output logic             run_o
);
    localparam logic [CYC_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CYC_W-1:0] cnt;
        logic             ovf;
        logic             en;
        logic             clr;
    } cyc_st_t;

    cyc_st_t st_d, st_q;
    logic    run;

    always_comb begin
        st_d = st_q;
        run  = st_q.en && !st_q.ovf;
        if (run) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = '0;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (we_i) begin
            st_d.en  = wr_en_i;
            st_d.clr = wr_clr_i;
            if (wr_clr_i && !st_q.clr) begin
                st_d.cnt = '0;
                st_d.ovf = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
    assign clr_o = st_q.clr;
    assign en_o  = st_q.en;
    assign run_o = run;

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !st_q.ovf && st_q.cnt != CNT_MAX && !we_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
    assert_wrap_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !st_q.ovf && st_q.cnt == CNT_MAX && !we_i) |=> (ovf_o && cnt_o == '0));
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !we_i) |=> ($stable(cnt_o) && ovf_o));
    assert_no_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ovf_o && clr_o) |=> ovf_o);
endmodule

// File: rtl/memperf_evt_cnt.sv
module memperf_evt_cnt
    import memperf_pkg::*;
#(
    parameter int EVT_W = 32,
    parameter int EV_N  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             wr_en_i,
    input  logic             wr_clr_i,
    input  sel_t             wr_sel_i,
    input  logic             run_i,
    input  logic             wrap_i,
    input  logic [EV_N-1:0]  events_i,
    output logic [EVT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             en_o,
    output sel_t             sel_o
);
    localparam logic [EVT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [EVT_W-1:0] cnt;
        logic             ovf;
        logic             en;
        sel_t             sel;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    hit, adv;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < EV_N; k++) begin
            if ((st_q.sel != '0) && (st_q.sel == SEL_W'(k))) hit = events_i[k];
        end
        adv  = st_q.en && run_i && hit && !(st_q.ovf && !wrap_i);
        st_d = st_q;
        if (adv) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
                st_d.cnt = wrap_i ? '0 : CNT_MAX;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (we_i) begin
            st_d.en  = wr_en_i;
            st_d.sel = wr_sel_i;
            if (!wr_clr_i) begin
                st_d.cnt = '0;
                st_d.ovf = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
    assign en_o  = st_q.en;
    assign sel_o = st_q.sel;

    assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !we_i) |=> $stable(cnt_o));
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !we_i) |=> $stable(cnt_o));
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && ovf_o && !we_i) |=> ($stable(cnt_o) && ovf_o));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wr_clr_i) |=> (cnt_o == '0 && !ovf_o));
endmodule

// File: rtl/memperf_monitor.sv
module memperf_monitor
    import memperf_pkg::*;
#(
    parameter int CYC_W  = 32,
    parameter int EVT_W  = 32,
    parameter int EV_N   = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_mode_i,
    input  logic [EV_N-1:0]   events_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(NUM_CNT);
    localparam int GRP_W = ADDR_W - IDX_W - 2;
    localparam logic [GRP_W-1:0] CTRL_GRP = GRP_W'(CTRL_OFS >> (IDX_W + 2));
    localparam logic [GRP_W-1:0] CNT_GRP  = GRP_W'(CNT_OFS >> (IDX_W + 2));

    logic              aligned;
    logic [IDX_W-1:0]  idx;
    logic [GRP_W-1:0]  grp;
    logic [NUM_CNT-1:0] ctrl_we;
    logic [DATA_W-1:0] ctrl_rd [NUM_CNT];
    logic [DATA_W-1:0] cnt_rd  [NUM_CNT];
    logic              wr_en, wr_clr;
    sel_t              wr_sel;

    logic [CYC_W-1:0]  cyc_cnt;
    logic              cyc_ovf, cyc_clr, cyc_en, cyc_run;

    assign aligned = (reg_addr_i[1:0] == 2'b00);
    assign idx     = reg_addr_i[IDX_W+1:2];
    assign grp     = reg_addr_i[ADDR_W-1:IDX_W+2];
    assign wr_en   = reg_wdata_i[EN_BIT];
    assign wr_clr  = reg_wdata_i[CLR_BIT];
    assign wr_sel  = reg_wdata_i[SEL_LSB +: SEL_W];

    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) begin
            ctrl_we[n] = reg_we_i && aligned && (grp == CTRL_GRP) && (idx == IDX_W'(n));
        end
    end

    memperf_cyc_cnt #(.CYC_W(CYC_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (ctrl_we[0]),
        .wr_en_i  (wr_en),
        .wr_clr_i (wr_clr),
        .cnt_o    (cyc_cnt),
        .ovf_o    (cyc_ovf),
        .clr_o    (cyc_clr),
        .en_o     (cyc_en),
        .run_o    (cyc_run)
    );

    always_comb begin
        ctrl_rd[0]          = '0;
        ctrl_rd[0][OVF_BIT] = cyc_ovf;
        ctrl_rd[0][CLR_BIT] = cyc_clr;
        ctrl_rd[0][EN_BIT]  = cyc_en;
        cnt_rd[0]           = DATA_W'(cyc_cnt);
    end

    for (genvar g = 1; g < NUM_CNT; g++) begin : g_evt
        logic [EVT_W-1:0] e_cnt;
        logic             e_ovf, e_en;
        sel_t             e_sel;

        memperf_evt_cnt #(.EVT_W(EVT_W), .EV_N(EV_N)) u_evt (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (ctrl_we[g]),
            .wr_en_i  (wr_en),
            .wr_clr_i (wr_clr),
            .wr_sel_i (wr_sel),
            .run_i    (cyc_run),
            .wrap_i   (wrap_mode_i),
            .events_i (events_i),
            .cnt_o    (e_cnt),
            .ovf_o    (e_ovf),
            .en_o     (e_en),
            .sel_o    (e_sel)
        );

        always_comb begin
            ctrl_rd[g]                      = '0;
            ctrl_rd[g][OVF_BIT]             = e_ovf;
            ctrl_rd[g][CLR_BIT]             = 1'b1;
            ctrl_rd[g][EN_BIT]              = e_en;
            ctrl_rd[g][SEL_LSB +: SEL_W]    = e_sel;
            cnt_rd[g]                       = DATA_W'(e_cnt);
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (aligned && grp == CTRL_GRP)     reg_rdata_o = ctrl_rd[idx];
        else if (aligned && grp == CNT_GRP) reg_rdata_o = cnt_rd[idx];
    end

    assign irq_o = cyc_ovf;

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctrl_we[0]) |=> irq_o);
    assert_irq_only_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !cyc_run) |=> !irq_o);
endmodule

// File: tb/memperf_monitor_bench.sv
`timescale 1ns/1ps
module memperf_monitor_bench;
    localparam int CYC_W = 10;
    localparam int EVT_W = 6;
    localparam int EV_N  = 64;
    localparam int ADDR_W = 6;
    localparam time TCLK = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wrap_mode = 1'b1;
    logic [EV_N-1:0]   events = '0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int total = 0;
    int bad = 0;

    memperf_monitor #(.CYC_W(CYC_W), .EVT_W(EVT_W), .EV_N(EV_N), .ADDR_W(ADDR_W)) u_memperf_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_mode_i (wrap_mode),
        .events_i    (events),
        .reg_we_i    (reg_we),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    always #(TCLK/2) clk = ~clk;

    // vector: [81:80] slot, [79:72] code, [71:8] strobes, [7:0] strobe cycles
    localparam logic [81:0] VEC [7] = '{
        {2'd1, 8'h04, 64'h0000_0000_0000_0010, 8'd7},
        {2'd2, 8'h05, 64'h0000_0000_0000_0010, 8'd7},
        {2'd3, 8'h20, 64'h0000_0001_0000_0000, 8'd9},
        {2'd1, 8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 8'd12},
        {2'd2, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5},
        {2'd3, 8'h80, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5},
        {2'd1, 8'h21, 64'h0000_0002_0000_0000, 8'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic strobe(input logic [EV_N-1:0] v, input int n);
        events = v;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check("R1 ctrl0", 6'h00, 32'h0);
        rd_check("R1 ctrl1", 6'h04, 32'h2);
        rd_check("R1 ctrl3", 6'h0C, 32'h2);
        rd_check("R1 cnt0",  6'h20, 32'h0);
        rd_check("R1 cnt2",  6'h28, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 unmapped and unaligned writes ignored, reads zero
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h01, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        wr(6'h24, 32'h0000_0055);
        repeat (3) @(negedge clk);
        rd_check("R2 unmapped 0x14", 6'h14, 32'h0);
        rd_check("R2 unmapped 0x30", 6'h30, 32'h0);
        rd_check("R2 unaligned 0x01", 6'h01, 32'h0);
        rd_check("R2 ctrl0 untouched", 6'h00, 32'h0);
        rd_check("R2 ctrl1 untouched", 6'h04, 32'h2);
        rd_check("R2 cnt1 read only", 6'h24, 32'h0);
        rd_check("R2 cnt0 idle", 6'h20, 32'h0);

        // R3 cycle counting: 10 idle cycles plus the disabling edge
        wr(6'h00, 32'hFF00_0006);
        repeat (10) @(negedge clk);
        wr(6'h00, 32'hFF00_0002);
        rd_check("R3 cnt0", 6'h20, 32'd11);
        rd_check("R3 ctrl0 code reads 0", 6'h00, 32'h2);

        // R4 table of selections and strobe patterns
        for (int i = 0; i < 7; i++) begin
            logic [1:0]      slot;
            logic [7:0]      code;
            logic [EV_N-1:0] ev;
            int              n;
            int              exp;
            slot = VEC[i][81:80];
            code = VEC[i][79:72];
            ev   = VEC[i][71:8];
            n    = int'(VEC[i][7:0]);
            exp  = 0;
            if (code != 8'h00 && code < 8'(EV_N) && ev[code[5:0]]) exp = n;
            wr({2'b00, slot, 2'b00}, {code, 24'h000004});
            wr(6'h00, 32'h0);
            wr(6'h00, 32'h6);
            strobe(ev, n);
            wr(6'h00, 32'h2);
            rd_check($sformatf("R4 vec%0d count", i), {2'b10, slot, 2'b00}, 32'(exp));
            rd_check($sformatf("R4 vec%0d ctrl", i), {2'b00, slot, 2'b00}, {code, 24'h000006});
            rd_check($sformatf("R3 vec%0d cycles", i), 6'h20, 32'(n + 1));
        end

        // R4 disabled slot ignores strobes
        wr(6'h08, 32'h0400_0000);
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h6);
        strobe('1, 5);
        wr(6'h00, 32'h2);
        rd_check("R4 disabled slot", 6'h28, 32'h0);

        // R6 cycle enable gates event slots
        wr(6'h0C, 32'h0500_0004);
        strobe('1, 6);
        rd_check("R6 stopped by cycle enable", 6'h2C, 32'h0);
        wr(6'h00, 32'h6);
        strobe('1, 4);
        wr(6'h00, 32'h2);
        rd_check("R6 resumed", 6'h2C, 32'd4);

        // R7 wrap mode: 70 strobes on a 6-bit slot
        wrap_mode = 1'b1;
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h0400_0004);
        wr(6'h00, 32'h6);
        strobe(64'h10, 70);
        wr(6'h00, 32'h2);
        rd_check("R7 wrapped count", 6'h24, 32'd6);
        rd_check("R7 flag set", 6'h04, 32'h0400_0007);
        check("R7 no irq", 32'(irq), 32'h0);

        // R8 stop mode: holds at all ones
        wrap_mode = 1'b0;
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h0400_0004);
        wr(6'h00, 32'h6);
        strobe(64'h10, 70);
        wr(6'h00, 32'h2);
        rd_check("R8 held count", 6'h24, 32'd63);
        rd_check("R8 flag set", 6'h04, 32'h0400_0007);
        check("R8 no irq", 32'(irq), 32'h0);
        wr(6'h00, 32'h6);
        strobe(64'h10, 5);
        wr(6'h00, 32'h2);
        rd_check("R8 still held", 6'h24, 32'd63);

        // R9 event clear by writing 0 to bit 1
        wr(6'h04, 32'h0400_0004);
        rd_check("R9 count zeroed", 6'h24, 32'h0);
        rd_check("R9 clear reads 1", 6'h04, 32'h0400_0006);

        // R5 cycle overflow locks everything
        wrap_mode = 1'b1;
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h6);
        strobe(64'h10, 3);
        repeat (1100) @(negedge clk);
        rd_check("R5 cnt0 wrapped", 6'h20, 32'h0);
        rd_check("R5 ctrl0 flag", 6'h00, 32'h7);
        check("R5 irq high", 32'(irq), 32'h1);
        rd_check("R5 slot1 before", 6'h24, 32'd3);
        strobe('1, 10);
        rd_check("R5 slot1 frozen", 6'h24, 32'd3);
        rd_check("R5 cnt0 frozen", 6'h20, 32'h0);
        check("R5 irq level", 32'(irq), 32'h1);

        // R10 cycle clear needs a 0 to 1 transition
        wr(6'h00, 32'h6);
        rd_check("R10 no clear on level", 6'h00, 32'h7);
        check("R10 irq kept", 32'(irq), 32'h1);
        wr(6'h00, 32'h4);
        rd_check("R10 clear low", 6'h00, 32'h5);
        wr(6'h00, 32'h2);
        rd_check("R10 cleared", 6'h00, 32'h2);
        rd_check("R10 cnt0 zero", 6'h20, 32'h0);
        check("R10 irq dropped", 32'(irq), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule